// File: doc/BRIEF.md
# GPIO Pad Configuration and Input Conditioning

This block controls a single general-purpose pad through one 32-bit configuration word. Software writes the word over a minimal register port and reads it back together with the live input state. On the receive side, the raw pad level crosses into the clock domain through a two-stage synchronizer. It can then pass through a stability filter or skip it. After that it can be forced high and inverted, and the result is shaped into an interrupt event: a level, a rising-edge pulse, an any-edge pulse, or nothing at all.

On the drive side, a zero mode field hands the pad output value and both buffer enables to the configuration word. Any non-zero mode hands them to a native function through pass-through ports, and the GPIO-only bits have no effect there. Two route enables forward the event to a peripheral interrupt line and to a system-control interrupt line. They take effect only when the pad is a GPIO input.

Top module: `gpio_pad_ctrl`

## Requirements
- R1: While reset is low, and after it, the configuration word reads 0x04000700: mode field (bits 12:10) = 1, input-off bit 9 = 1, output-off bit 8 = 1, event field (bits 26:25) = 2, and all other bits 0. The event output is 0.
- R2: A write stores only bits 28, 26:24, 23, 20, 19, 12:8 and 0. Every other bit, including reserved bits 16:13 and 7:2, reads 0. Bit 1 always reads the live input state.
- R3: With mode 0: pad_out equals bit 0, pad_oe equals the inverse of bit 8, and pad_ie equals the inverse of bit 9.
- R4: With any non-zero mode: pad_out, pad_oe and pad_ie follow nat_out, nat_oe and nat_ie. Bits 0, 8 and 9 have no effect.
- R5: With bit 24 = 0 (filter bypassed), a change on pad_in appears on bit 1 after the second rising clock edge.
- R6: With bit 24 = 1, a new level reaches bit 1 only after the synchronized input has held it for STABLE cycles (default 4). A level step appears after the sixth edge. A 3-cycle pulse on pad_in never appears.
- R7: Bit 1 shows the selected (filtered or bypassed) state. It is unaffected by the force bit 28, the invert bit 23 and the mode field.
- R8: The conditioned state is (selected state OR bit 28) XOR bit 23. It drives nat_rx and feeds the event stage.
- R9: Event field 0 passes the conditioned state to evt as a level. Event field 2 holds evt at 0.
- R10: Event field 1 makes evt a one-cycle pulse in the cycle the conditioned state rises. Event field 3 makes it a one-cycle pulse on a rise or a fall.
- R11: irq_req equals evt AND bit 20, and sci_req equals evt AND bit 19. Both are 0 unless the mode is 0 and bit 9 is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Configuration write strobe |
| reg_wdata | input | 32 | Configuration write data |
| reg_rdata | output | 32 | Configuration word with live input state in bit 1 |
| pad_in | input | 1 | Raw asynchronous pad input |
| pad_out | output | 1 | Pad output value |
| pad_oe | output | 1 | Pad output buffer enable |
| pad_ie | output | 1 | Pad input buffer enable |
| nat_out | input | 1 | Native function output value |
| nat_oe | input | 1 | Native function output enable |
| nat_ie | input | 1 | Native function input enable |
| nat_rx | output | 1 | Conditioned receive state to the native function |
| evt | output | 1 | Shaped event |
| irq_req | output | 1 | Peripheral interrupt route |
| sci_req | output | 1 | System-control interrupt route |

## Verification
The assertions assume that pad_in is the only asynchronous input. They also assume that register writes are single-cycle strobes whose data is stable at the clock edge. The bench therefore changes every input just after a falling edge, so each value is settled for a full half period before it is sampled.

The filter property assumes that the synchronized input is what the filter observes. It does not hold for pulses shorter than one clock. The bench therefore builds every glitch from whole clock cycles of pad_in.

// File: rtl/gpio_pad_pkg.sv
package gpio_pad_pkg;
  localparam int CFG_W     = 32;
  localparam int B_FORCE   = 28;
  localparam int B_EVT_LO  = 25;
  localparam int B_FSEL    = 24;
  localparam int B_INV     = 23;
  localparam int B_IRQ_EN  = 20;
  localparam int B_SCI_EN  = 19;
  localparam int B_MODE_LO = 10;
  localparam int MODE_W    = 3;
  localparam int B_RX_OFF  = 9;
  localparam int B_TX_OFF  = 8;
  localparam int B_RX_ST   = 1;
  localparam int B_TX_VAL  = 0;
  localparam logic [CFG_W-1:0] CFG_KEEP  = 32'h1798_1F01;
  localparam logic [CFG_W-1:0] CFG_RESET = 32'h0400_0700;

  typedef enum logic [1:0] {
    EVT_LEVEL = 2'd0,
    EVT_RISE  = 2'd1,
    EVT_OFF   = 2'd2,
    EVT_BOTH  = 2'd3
  } evt_mode_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q, chain_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb chain_d = d;
    end else begin : g_many
      always_comb chain_d = {chain_q[STAGES-2:0], d};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_glitch_filt.sv
module gpio_glitch_filt #(
  parameter int STABLE = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  localparam int CNT_W = (STABLE < 2) ? 1 : $clog2(STABLE + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STABLE - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             lvl_q, lvl_d;

  always_comb begin
    cnt_d = '0;
    lvl_d = lvl_q;
    if (d != lvl_q) begin
      if (cnt_q == CNT_LAST) lvl_d = d;
      else                   cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lvl_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      lvl_q <= lvl_d;
    end
  end

  assign q = lvl_q;
endmodule

// File: rtl/gpio_evt_shape.sv
module gpio_evt_shape
  import gpio_pad_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      cond,
  input  evt_mode_e mode,
  output logic      evt
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= cond;
  end

  always_comb begin
    unique case (mode)
      EVT_LEVEL: evt = cond;
      EVT_RISE:  evt = cond & ~prev_q;
      EVT_BOTH:  evt = cond ^ prev_q;
      default:   evt = 1'b0;
    endcase
  end
endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl
  import gpio_pad_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_STABLE = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [CFG_W-1:0] reg_wdata,
  output logic [CFG_W-1:0] reg_rdata,
  input  logic             pad_in,
  output logic             pad_out,
  output logic             pad_oe,
  output logic             pad_ie,
  input  logic             nat_out,
  input  logic             nat_oe,
  input  logic             nat_ie,
  output logic             nat_rx,
  output logic             evt,
  output logic             irq_req,
  output logic             sci_req
);
  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // configuration word
  logic [CFG_W-1:0] cfg_q, cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (reg_we) cfg_d = reg_wdata & CFG_KEEP;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) cfg_q <= CFG_RESET;
    else            cfg_q <= cfg_d;
  end

  logic [MODE_W-1:0] mode;
  logic              gpio_mode, gpio_input;

  assign mode       = cfg_q[B_MODE_LO +: MODE_W];
  assign gpio_mode  = (mode == '0);
  assign gpio_input = gpio_mode & ~cfg_q[B_RX_OFF];

  // receive path
  logic sync_rx, filt_rx, sel_rx, cond;

  gpio_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_int_n), .d(pad_in), .q(sync_rx)
  );

  gpio_glitch_filt #(.STABLE(FILT_STABLE)) u_filt (
    .clk(clk), .rst_n(rst_int_n), .d(sync_rx), .q(filt_rx)
  );

  assign sel_rx = cfg_q[B_FSEL] ? filt_rx : sync_rx;
  assign cond   = (sel_rx | cfg_q[B_FORCE]) ^ cfg_q[B_INV];
  assign nat_rx = cond;

  gpio_evt_shape u_evt (
    .clk(clk), .rst_n(rst_int_n), .cond(cond),
    .mode(evt_mode_e'(cfg_q[B_EVT_LO +: 2])), .evt(evt)
  );

  assign irq_req = evt & cfg_q[B_IRQ_EN] & gpio_input;
  assign sci_req = evt & cfg_q[B_SCI_EN] & gpio_input;

  // drive path
  always_comb begin
    if (gpio_mode) begin
      pad_out = cfg_q[B_TX_VAL];
      pad_oe  = ~cfg_q[B_TX_OFF];
      pad_ie  = ~cfg_q[B_RX_OFF];
    end else begin
      pad_out = nat_out;
      pad_oe  = nat_oe;
      pad_ie  = nat_ie;
    end
  end

  // readback
  always_comb begin
    reg_rdata          = cfg_q;
    reg_rdata[B_RX_ST] = sel_rx;
  end
endmodule

// File: rtl/gpio_pad_chk.sv
module gpio_pad_chk
  import gpio_pad_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [CFG_W-1:0] reg_rdata,
  input logic             evt,
  input logic             irq_req,
  input logic             sci_req,
  input logic             cond,
  input logic             sync_rx,
  input logic             filt_rx
);
  // R2: reserved bits never read as 1
  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata & ~(CFG_KEEP | 32'h2)) == '0);

  // R11: routes stay quiet outside GPIO input mode
  a_r11_route_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req || sci_req) |->
      (reg_rdata[B_MODE_LO +: MODE_W] == '0 && !reg_rdata[B_RX_OFF] && evt));

  // R6: filter only moves to a level the synchronizer already held
  a_r6_filter_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_rx != $past(filt_rx)) |-> ($past(sync_rx) == filt_rx));

  // R10: rise mode pulses only when the conditioned state rose
  a_r10_rise_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[B_EVT_LO +: 2] == 2'd1 && evt) |-> $rose(cond));

  // R9: disabled event mode never signals
  a_r9_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[B_EVT_LO +: 2] == 2'd2) |-> !evt);
endmodule

bind gpio_pad_ctrl gpio_pad_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_rdata(reg_rdata), .evt(evt),
  .irq_req(irq_req), .sci_req(sci_req), .cond(cond),
  .sync_rx(sync_rx), .filt_rx(filt_rx)
);

// File: tb/sim_gpio_pad_ctrl.sv
module sim_gpio_pad_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic [31:0] reg_wdata, reg_rdata;
  logic        pad_in, pad_out, pad_oe, pad_ie;
  logic        nat_out, nat_oe, nat_ie, nat_rx;
  logic        evt, irq_req, sci_req;

  int n_chk = 0;
  int n_bad = 0;

  localparam logic [31:0] KEEP = 32'h1798_1F01;

  always #4 clk = ~clk;

  gpio_pad_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .pad_in(pad_in), .pad_out(pad_out),
    .pad_oe(pad_oe), .pad_ie(pad_ie), .nat_out(nat_out), .nat_oe(nat_oe),
    .nat_ie(nat_ie), .nat_rx(nat_rx), .evt(evt), .irq_req(irq_req),
    .sci_req(sci_req)
  );

  typedef struct packed {
    logic [31:0] cfg;
    logic pad, no, noe, nie;
    logic pout, poe, pie, rb, ev, irq, sci;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{32'h0010_0001, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0},
    '{32'h0090_0001, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
    '{32'h0008_0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    '{32'h1008_0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1},
    '{32'h0018_0200, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
    '{32'h0010_0701, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0},
    '{32'h0080_1400, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
    '{32'h0010_0101, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [31:0] d);
    reg_we = 1'b1;
    reg_wdata = d;
    tick(1);
    reg_we = 1'b0;
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    n_chk++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_we = 1'b0; reg_wdata = '0; pad_in = 1'b0;
    nat_out = 1'b1; nat_oe = 1'b0; nat_ie = 1'b1;
    tick(2);
    // R1 reset state; R4 native pass-through in reset mode 1
    chk("R1 reset word", reg_rdata, 32'h0400_0700);
    chk("R1 reset evt", {31'b0, evt}, 32'h0);
    chk("R4 reset pad drive", {29'b0, pad_out, pad_oe, pad_ie}, {29'b0, nat_out, nat_oe, nat_ie});
    rst_n = 1'b1;
    tick(4);
    chk("R1 after release", reg_rdata, 32'h0400_0700);

    // vector table: R3 R4 R7 R8 R9 R11 with filter bypassed, level events
    foreach (VECS[i]) begin
      pad_in = VECS[i].pad; nat_out = VECS[i].no; nat_oe = VECS[i].noe; nat_ie = VECS[i].nie;
      wr(VECS[i].cfg);
      tick(4);
      chk("R2 readback", reg_rdata, (VECS[i].cfg & KEEP) | {30'b0, VECS[i].rb, 1'b0});
      chk("R3/R4 pad drive", {29'b0, pad_out, pad_oe, pad_ie},
          {29'b0, VECS[i].pout, VECS[i].poe, VECS[i].pie});
      chk("R7 rx state", {31'b0, reg_rdata[1]}, {31'b0, VECS[i].rb});
      chk("R8/R9 level evt", {30'b0, evt, nat_rx}, {30'b0, VECS[i].ev, VECS[i].ev});
      chk("R11 routes", {30'b0, irq_req, sci_req}, {30'b0, VECS[i].irq, VECS[i].sci});
    end

    // R2 all-ones write keeps only the writable bits
    pad_in = 1'b0;
    wr(32'hFFFF_FFFF);
    tick(4);
    chk("R2 reserved ignore", reg_rdata, KEEP);

    // R5 bypass latency
    wr(32'h0010_0000);
    tick(4);
    pad_in = 1'b1;
    tick(1);
    chk("R5 one edge", {31'b0, reg_rdata[1]}, 32'h0);
    tick(1);
    chk("R5 two edges", {31'b0, reg_rdata[1]}, 32'h1);

    // R6 filter step: appears after sixth edge
    pad_in = 1'b0;
    wr(32'h0110_0000);
    tick(10);
    chk("R6 settled low", {31'b0, reg_rdata[1]}, 32'h0);
    pad_in = 1'b1;
    tick(5);
    chk("R6 fifth edge", {31'b0, reg_rdata[1]}, 32'h0);
    tick(1);
    chk("R6 sixth edge", {31'b0, reg_rdata[1]}, 32'h1);
    pad_in = 1'b0;
    tick(10);
    // R6 three-cycle glitch rejected
    pad_in = 1'b1;
    tick(3);
    pad_in = 1'b0;
    for (int k = 0; k < 10; k++) begin
      tick(1);
      chk("R6 glitch rejected", {30'b0, reg_rdata[1], evt}, 32'h0);
    end

    // R10 rise mode
    wr(32'h0210_0000);
    tick(4);
    pad_in = 1'b1;
    tick(1);
    chk("R10 rise before", {31'b0, evt}, 32'h0);
    tick(1);
    chk("R10 rise pulse", {30'b0, evt, irq_req}, 32'h3);
    tick(1);
    chk("R10 rise end", {31'b0, evt}, 32'h0);
    pad_in = 1'b0;
    tick(2);
    chk("R10 no fall pulse", {31'b0, evt}, 32'h0);
    tick(2);

    // R10 both edges
    wr(32'h0610_0000);
    tick(2);
    pad_in = 1'b1;
    tick(2);
    chk("R10 both rise", {31'b0, evt}, 32'h1);
    tick(1);
    chk("R10 both rise end", {31'b0, evt}, 32'h0);
    pad_in = 1'b0;
    tick(2);
    chk("R10 both fall", {31'b0, evt}, 32'h1);
    tick(1);
    chk("R10 both fall end", {31'b0, evt}, 32'h0);

    // R9 off mode with high conditioned state
    wr(32'h1410_0000);
    tick(4);
    chk("R9 off mode", {30'b0, evt, nat_rx}, 32'h1);

    // R1 reset mid-run
    rst_n = 1'b0;
    tick(1);
    chk("R1 mid-run reset", reg_rdata, 32'h0400_0700);
    rst_n = 1'b1;
    tick(4);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule